// File: doc/BRIEF.md
# Operand-Latched Four-Function ALU with Zero Flag

This block is the arithmetic stage of a small bus-based datapath. Two 16-bit operand registers each take the value on a shared bus when their load strobe is high. A combinational function unit combines the two registered operands under a 2-bit function code. A drive-enable pin gates the result onto the block's bus output. A separate flag register records whether the result is zero, so that a branch sequencer can test it in a later cycle.

The main use is a register comparison. The two values are latched into the operands, the subtract function is selected, and the zero flag is loaded. The increment function serves as the program-counter adder, and it ignores the second operand. All arithmetic wraps at 16 bits. The block has no carry or overflow outputs.

The data path is a plain strobe-driven datapath element, not a stream. It has no valid/ready handshake and no back-pressure. Every strobe acts on the rising clock edge at which it is sampled high.

Top module: `alu_zero_unit`

## Requirements
- R1: After reset the block behaves as if both operand registers and the zero flag hold 0. With function code 11 and drive enabled, `bus_out` reads 0x0001, and `zflag` reads 0.
- R2: When `ld_opa` is high at a rising edge, operand A takes `bus_in`. When it is low, A keeps its value.
- R3: When `ld_opb` is high at a rising edge, operand B takes `bus_in`. When it is low, B keeps its value.
- R4: Function code 00 gives (A + B) mod 2^16.
- R5: Function code 01 gives the bitwise inverse of (A AND B).
- R6: Function code 10 gives (A - B) mod 2^16.
- R7: Function code 11 gives (A + 1) mod 2^16, and B has no effect on the result.
- R8: `bus_out` equals the function result in the same cycle while `drive_en` is high. It is 0x0000 while `drive_en` is low.
- R9: At a rising edge with `ld_zflag` high, `zflag` becomes 1 if the result is 0x0000 and becomes 0 otherwise. With `ld_zflag` low, `zflag` holds.
- R10: The zero flag is computed from the operands held before the edge. An operand load at the same edge does not affect the flag value captured at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 16 | Shared bus value offered to the operand registers |
| ld_opa | input | 1 | Load strobe for operand A |
| ld_opb | input | 1 | Load strobe for operand B |
| fn_sel | input | 2 | Function code: 00 add, 01 nand, 10 subtract, 11 increment A |
| drive_en | input | 1 | Gates the result onto `bus_out` |
| ld_zflag | input | 1 | Load strobe for the zero flag |
| bus_out | output | 16 | Result while `drive_en` is high, otherwise zero |
| zflag | output | 1 | Registered zero indication |

## Verification
The assertions assume that every strobe and the function code are known values, 0 or 1, at each sampled edge after reset. They also assume that `bus_in` is stable around the edge at which a load takes it. The bench drives every input only at the falling edge from fixed-seed `$urandom` values, so all inputs are always defined and settle half a period before the capturing edge. The directed cases cover equal operands under subtract, an all-ones increment, an all-ones nand, and a flag load at the same edge as an operand load.

// File: rtl/alu_zero_pkg.sv
package alu_zero_pkg;
  localparam int unsigned FN_W = 2;

  typedef enum logic [FN_W-1:0] {
    FN_ADD  = 2'b00,
    FN_NAND = 2'b01,
    FN_SUB  = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;
endpackage

// File: rtl/alu_operand_reg.sv
module alu_operand_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_OPND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R2
  AST_OPND_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(d)); // R3
endmodule

// File: rtl/alu_func_unit.sv
module alu_func_unit
  import alu_zero_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]    opa,
  input  logic [W-1:0]    opb,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    res
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    unique case (alu_fn_e'(fn))
      FN_ADD:  res = opa + opb;
      FN_NAND: res = ~(opa & opb);
      FN_SUB:  res = opa - opb;
      FN_INC:  res = opa + ONE;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_zero_flag.sv
module alu_zero_flag #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] res,
  output logic         z
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    z <= 1'b0;
    else if (load) z <= (res == '0);
  end

  AST_Z_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(z)); // R9
endmodule

// File: rtl/alu_zero_unit.sv
module alu_zero_unit
  import alu_zero_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] bus_in,
  input  logic             ld_opa,
  input  logic             ld_opb,
  input  logic [1:0]       fn_sel,
  input  logic             drive_en,
  input  logic             ld_zflag,
  output logic [WIDTH-1:0] bus_out,
  output logic             zflag
);
  logic [WIDTH-1:0] opa_q, opb_q, alu_res;

  alu_operand_reg #(.W(WIDTH)) u_opa (
    .clk(clk), .rst_n(rst_n), .load(ld_opa), .d(bus_in), .q(opa_q));
  alu_operand_reg #(.W(WIDTH)) u_opb (
    .clk(clk), .rst_n(rst_n), .load(ld_opb), .d(bus_in), .q(opb_q));

  alu_func_unit #(.W(WIDTH)) u_fn (
    .opa(opa_q), .opb(opb_q), .fn(fn_sel), .res(alu_res));

  alu_zero_flag #(.W(WIDTH)) u_zf (
    .clk(clk), .rst_n(rst_n), .load(ld_zflag), .res(alu_res), .z(zflag));

  assign bus_out = drive_en ? alu_res : '0;

  AST_Z_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_zflag |=> zflag == ($past(bus_out) == '0 || !$past(drive_en) ? ($past(alu_res) == '0) : 1'b0)); // R9
  AST_Z_OLD_OPND: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_zflag && ld_opa) |=> zflag == ($past(alu_res) == '0)); // R10
  AST_INC_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_opa && !ld_opb) |=> (fn_sel != 2'b11) || (alu_res == $past(bus_in) + WIDTH'(1))); // R7
  always_comb begin
    if (rst_n && !drive_en)
      AST_BUS_IDLE: assert (bus_out == '0); // R8
  end
endmodule

// File: tb/alu_zero_unit_tb.sv
`timescale 1ns/1ps
module alu_zero_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_in = '0;
  logic        ld_opa = 1'b0, ld_opb = 1'b0, drive_en = 1'b0, ld_zflag = 1'b0;
  logic [1:0]  fn_sel = '0;
  logic [15:0] bus_out;
  logic        zflag;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [15:0] ma = '0, mb = '0;
  logic        mz = 1'b0;

  always #2.5 clk = ~clk;

  alu_zero_unit u_dut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .ld_opa(ld_opa), .ld_opb(ld_opb),
    .fn_sel(fn_sel), .drive_en(drive_en), .ld_zflag(ld_zflag),
    .bus_out(bus_out), .zflag(zflag));

  function automatic logic [15:0] ref_fn(input logic [15:0] a, input logic [15:0] b,
                                         input logic [1:0] f);
    case (f)
      2'b00:   return a + b;
      2'b01:   return ~(a & b);
      2'b10:   return a - b;
      default: return a + 16'd1;
    endcase
  endfunction

  function automatic string fn_tag(input logic [1:0] f);
    case (f)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [15:0] b, input logic la, input logic lb,
                     input logic [1:0] f, input logic de, input logic lz, input string ztag);
    logic [15:0] r;
    bus_in = b; ld_opa = la; ld_opb = lb; fn_sel = f; drive_en = de; ld_zflag = lz;
    #1;
    r = ref_fn(ma, mb, f);
    check(de ? fn_tag(f) : "R8", bus_out, de ? r : 16'h0000);
    @(posedge clk);
    if (lz) mz = (r == 16'h0000);
    if (la) ma = b;
    if (lb) mb = b;
    @(negedge clk);
    check(ztag, {15'b0, zflag}, {15'b0, mz});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    fn_sel = 2'b11; drive_en = 1'b1; #1;
    check("R1", bus_out, 16'h0001);
    check("R1", {15'b0, zflag}, 16'h0000);
    // R2 / R3: load and hold
    cyc(16'h1234, 1, 0, 2'b00, 1, 0, "R2");
    cyc(16'h0FF0, 0, 1, 2'b00, 1, 0, "R3");
    cyc(16'hAAAA, 0, 0, 2'b00, 1, 0, "R2");
    check("R2", bus_out, 16'h1234 + 16'h0FF0);
    // R6 / R9: equal operands give zero flag
    cyc(16'h4321, 1, 1, 2'b10, 1, 0, "R9");
    cyc(16'h0000, 0, 0, 2'b10, 1, 1, "R9");
    check("R9", {15'b0, zflag}, 16'h0001);
    // R9: flag hold while load low
    cyc(16'h0001, 1, 0, 2'b10, 0, 0, "R9");
    check("R9", {15'b0, zflag}, 16'h0001);
    // R10: flag load with simultaneous operand load uses old operands (A=1,B=4321)
    cyc(16'h4321, 1, 0, 2'b10, 1, 1, "R10");
    check("R10", {15'b0, zflag}, 16'h0000);
    // R7: increment wraps, B ignored
    cyc(16'hFFFF, 1, 0, 2'b11, 1, 0, "R7");
    cyc(16'h5555, 0, 1, 2'b11, 1, 1, "R7");
    check("R7", {15'b0, zflag}, 16'h0001);
    // R5: all-ones nand
    cyc(16'hFFFF, 0, 1, 2'b01, 1, 1, "R5");
    cyc(16'h0000, 0, 0, 2'b01, 1, 1, "R5");
    check("R5", {15'b0, zflag}, 16'h0001);
    // R4 wrap
    cyc(16'h0001, 0, 1, 2'b00, 1, 1, "R4");
    cyc(16'h0000, 0, 0, 2'b00, 1, 1, "R4");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] rb;
      logic [1:0]  rf;
      rb = 16'($urandom);
      if (($urandom % 4) == 0) rb = ma;
      rf = 2'($urandom);
      cyc(rb, 1'($urandom), 1'($urandom), rf, 1'($urandom), 1'($urandom), "R9");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule